// File: doc/BRIEF.md
# Snapshot/FIFO Output Sample Buffer

This block holds up to eight output samples between a sample-producing datapath and a host read port. A configuration word picks one of two capture modes. In FIFO mode every valid sample is stored, and the block raises a one-cycle interrupt and a sticky READY flag when the fill level climbs to a programmed threshold. In snapshot mode a sample-time interval counter expires periodically. Each expiry starts a burst that stores a programmed number of consecutive samples.

The host reads the buffer through three command strobes. An advance strobe consumes one entry and shows it on the read port. A clear strobe empties the buffer and puts the pointers in their home positions. A sync strobe produces a single-cycle pulse on a dedicated output. A write that meets a full buffer is dropped and sets a sticky overflow flag. Everything runs on one clock.

Top module: `snap_fifo_buf`

## Requirements
- R1: After reset the level is 0 and irq, ready, ovf and syncout are low. The configuration word is zero, which selects snapshot mode with interval field 0 and count field 0.
- R2: Configuration word layout: bit 0 is the mode (1 = FIFO, 0 = snapshot), bits 3:1 are the threshold, bits 11:4 are the interval field and bits 15:12 are the burst count. In FIFO mode every valid sample is stored in arrival order. An advance strobe on a non-empty buffer removes the oldest entry, and that entry appears on rd_data in the cycle after the strobe.
- R3: A sample that is to be stored while the level is 8 is discarded, the level stays at 8 and ovf is set. ovf stays high until a clear strobe.
- R4: In FIFO mode, irq is high for exactly one cycle, the cycle after a store without a simultaneous advance raises the level to the threshold. A threshold of 0 never fires.
- R5: ready rises together with irq. It drops in the cycle after the level becomes lower than the threshold, and it is also cleared by a clear strobe.
- R6: In snapshot mode, with interval field V, a burst starts on every (V+1)-th valid sample counted since reset or the last mode change. The first burst starts on sample index V.
- R7: A burst stores the expiring sample and the samples that directly follow it, N in total. A count field of 0 acts as 1 and a count field above 8 acts as 8. A burst stops at the first sample that meets a full buffer.
- R8: A clear strobe sets the read pointer to 7 and the write pointer to 0 and empties the buffer. The next stored sample is returned by the first advance that follows.
- R9: An advance strobe on an empty buffer has no effect: the level stays 0 and rd_data does not change.
- R10: Each cycle in which cmd_sync is high produces syncout high in exactly the next cycle.
- R11: A configuration write that changes the mode bit restarts the interval counter and ends any burst in progress. Stored entries and the level are kept.
- R12: level always equals the number of stored, unread samples (0 to 8), and it agrees with the distance between the write and read pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word (layout in R2) |
| cmd_clr | input | 1 | Clear strobe: empty buffer, home pointers |
| cmd_adv | input | 1 | Advance strobe: consume one entry |
| cmd_sync | input | 1 | Sync strobe request |
| smp_vld | input | 1 | Sample valid from datapath |
| smp_data | input | 16 | Sample value |
| rd_data | output | 16 | Entry at the read pointer |
| level | output | 4 | Number of unread entries |
| irq | output | 1 | Threshold interrupt pulse |
| ready | output | 1 | Threshold reached flag |
| ovf | output | 1 | Sticky overflow flag |
| syncout | output | 1 | One-cycle sync pulse |

## Verification
The assertions check on every cycle that the level stays within 0 to 8 and matches the pointer distance. They also check that irq is an isolated pulse with ready already set, that overflow holds until cleared, that a clear strobe homes both pointers, that an advance on an empty buffer cannot drain it, and that syncout follows its strobe. Data order, snapshot spacing, burst length with count clamping, and survival of stored data across a mode switch depend on sequences of samples. Only the bench's directed and random scenarios, compared against its reference model, can show those.

// File: rtl/sob_pkg.sv
`timescale 1ns/1ps
package sob_pkg;
  localparam int SOB_THR_W = 3;
  localparam int SOB_IVL_W = 8;
  localparam int SOB_CNT_W = 4;
  localparam int SOB_CFG_W = 1 + SOB_THR_W + SOB_IVL_W + SOB_CNT_W;

  typedef struct packed {
    logic [SOB_CNT_W-1:0] burst;
    logic [SOB_IVL_W-1:0] ivl;
    logic [SOB_THR_W-1:0] thr;
    logic                 fifo;
  } sob_cfg_t;

  // Map a programmed burst count into 1..lim
  function automatic logic [SOB_CNT_W-1:0] sob_clamp(logic [SOB_CNT_W-1:0] c,
                                                     logic [SOB_CNT_W-1:0] lim);
    if (c == '0)      return SOB_CNT_W'(1);
    else if (c > lim) return lim;
    else              return c;
  endfunction
endpackage

// File: rtl/sob_store.sv
`timescale 1ns/1ps
module sob_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [OW-1:0] occ,
  output logic [OW-1:0] occ_nxt,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_nxt, rd_nxt;
  logic          full, empty;

  assign full    = (occ == OW'(DEPTH));
  assign empty   = (occ == '0);
  assign push_ok = push_req && !full;
  assign drop    = push_req && full;
  assign pop_ok  = pop_req && !empty;
  assign rdata   = mem[rd_ptr];

  always_comb begin
    wr_nxt  = wr_ptr;
    rd_nxt  = rd_ptr;
    occ_nxt = occ;
    if (clr) begin
      wr_nxt  = '0;
      rd_nxt  = '1;
      occ_nxt = '0;
    end else begin
      if (push_ok) wr_nxt = wr_ptr + AW'(1);
      if (pop_ok)  rd_nxt = rd_ptr + AW'(1);
      if (push_ok && !pop_ok)      occ_nxt = occ + OW'(1);
      else if (pop_ok && !push_ok) occ_nxt = occ - OW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '1;
      occ    <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      occ    <= occ_nxt;
    end
  end

  // Storage array carries no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/sob_snap.sv
`timescale 1ns/1ps
module sob_snap #(
  parameter int IW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          fifo_mode,
  input  logic          restart,
  input  logic          full,
  input  logic [IW-1:0] ivl_lim,
  input  logic [CW-1:0] burst_len,
  output logic          take
);
  logic [IW-1:0] ivl_q, ivl_d;
  logic [CW-1:0] left_q, left_d;
  logic          expire;

  assign expire = !fifo_mode && smp_vld && (ivl_q == ivl_lim);
  assign take   = expire || (!fifo_mode && smp_vld && (left_q != '0));

  always_comb begin
    ivl_d  = ivl_q;
    left_d = left_q;
    if (restart || fifo_mode) begin
      ivl_d  = '0;
      left_d = '0;
    end else if (smp_vld) begin
      if (expire) begin
        ivl_d  = '0;
        left_d = full ? '0 : burst_len - CW'(1);
      end else begin
        ivl_d = ivl_q + IW'(1);
        if (left_q != '0) left_d = full ? '0 : left_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      left_q <= '0;
    end else begin
      ivl_q  <= ivl_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/sob_flags.sv
`timescale 1ns/1ps
module sob_flags #(
  parameter int OW = 4,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic [TW-1:0] thr,
  input  logic          clr,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic          drop,
  input  logic [OW-1:0] occ_nxt,
  input  logic          sync_req,
  output logic          irq,
  output logic          ready,
  output logic          ovf,
  output logic          syncout
);
  logic irq_d, ready_d, ovf_d;

  always_comb begin
    irq_d = fifo_mode && push_ok && !pop_ok && !clr && (occ_nxt == OW'(thr));
    if (clr)                       ready_d = 1'b0;
    else if (irq_d)                ready_d = 1'b1;
    else if (occ_nxt < OW'(thr))   ready_d = 1'b0;
    else                           ready_d = ready;
    if (clr)       ovf_d = 1'b0;
    else if (drop) ovf_d = 1'b1;
    else           ovf_d = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      ready   <= 1'b0;
      ovf     <= 1'b0;
      syncout <= 1'b0;
    end else begin
      irq     <= irq_d;
      ready   <= ready_d;
      ovf     <= ovf_d;
      syncout <= sync_req;
    end
  end
endmodule

// File: rtl/snap_fifo_buf.sv
`timescale 1ns/1ps
module snap_fifo_buf
  import sob_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [SOB_CFG_W-1:0]       cfg_wdata,
  input  logic                       cmd_clr,
  input  logic                       cmd_adv,
  input  logic                       cmd_sync,
  input  logic                       smp_vld,
  input  logic [DW-1:0]              smp_data,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       irq,
  output logic                       ready,
  output logic                       ovf,
  output logic                       syncout
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH + 1);

  sob_cfg_t      cfg_q, cfg_d, cfg_w;
  logic          mode_chg, snap_take, store_req;
  logic          push_ok, pop_ok, drop;
  logic [OW-1:0] occ_nxt;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [SOB_CNT_W-1:0] burst_eff;

  assign cfg_w     = sob_cfg_t'(cfg_wdata);
  assign mode_chg  = cfg_we && (cfg_w.fifo != cfg_q.fifo);
  assign burst_eff = sob_clamp(cfg_q.burst, SOB_CNT_W'(DEPTH));
  assign store_req = (cfg_q.fifo && smp_vld) || snap_take;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  sob_snap #(.IW(SOB_IVL_W), .CW(SOB_CNT_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .fifo_mode (cfg_q.fifo),
    .restart   (mode_chg),
    .full      (level == OW'(DEPTH)),
    .ivl_lim   (cfg_q.ivl),
    .burst_len (burst_eff),
    .take      (snap_take)
  );

  sob_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cmd_clr),
    .push_req (store_req),
    .pop_req  (cmd_adv),
    .wdata    (smp_data),
    .rdata    (rd_data),
    .occ      (level),
    .occ_nxt  (occ_nxt),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .drop     (drop)
  );

  sob_flags #(.OW(OW), .TW(SOB_THR_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (cfg_q.fifo),
    .thr       (cfg_q.thr),
    .clr       (cmd_clr),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .drop      (drop),
    .occ_nxt   (occ_nxt),
    .sync_req  (cmd_sync),
    .irq       (irq),
    .ready     (ready),
    .ovf       (ovf),
    .syncout   (syncout)
  );
endmodule

// File: rtl/sob_chk.sv
`timescale 1ns/1ps
module sob_chk #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_clr,
  input logic          cmd_adv,
  input logic          cmd_sync,
  input logic [OW-1:0] level,
  input logic          irq,
  input logic          ready,
  input logic          ovf,
  input logic          syncout,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr
);
  p_level_max_r12: assert property (@(posedge clk) disable iff (!rst_n)
    level <= OW'(DEPTH));

  p_ptr_track_r12: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(wr_ptr - rd_ptr - AW'(1)) == level[AW-1:0]);

  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cmd_clr) |=> ovf);

  p_clr_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> (level == '0 && !ready && !ovf && wr_ptr == '0 && rd_ptr == '1));

  p_adv_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_adv && level == '0) |=> (level <= OW'(1)));

  p_sync_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sync |=> syncout);

  p_sync_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_sync |=> !syncout);
endmodule

bind snap_fifo_buf sob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_clr  (cmd_clr),
  .cmd_adv  (cmd_adv),
  .cmd_sync (cmd_sync),
  .level    (level),
  .irq      (irq),
  .ready    (ready),
  .ovf      (ovf),
  .syncout  (syncout),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr)
);

// File: tb/sim_snap_fifo_buf.sv
`timescale 1ns/1ps
module sim_snap_fifo_buf;
  localparam int DW    = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cmd_clr, cmd_adv, cmd_sync, smp_vld;
  logic [15:0]   cfg_wdata;
  logic [DW-1:0] smp_data;
  logic [DW-1:0] rd_data;
  logic [3:0]    level;
  logic          irq, ready, ovf, syncout;

  always #10 clk = ~clk;

  snap_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cmd_clr(cmd_clr), .cmd_adv(cmd_adv), .cmd_sync(cmd_sync),
    .smp_vld(smp_vld), .smp_data(smp_data), .rd_data(rd_data),
    .level(level), .irq(irq), .ready(ready), .ovf(ovf), .syncout(syncout)
  );

  int n_chk = 0;
  int n_err = 0;
  int irq_seen = 0;

  // Reference model state
  logic [15:0]   m_cfg;
  int            m_occ, m_ivl, m_burst;
  bit            m_ready, m_ovf, e_irq, e_sync, e_rd_vld;
  logic [DW-1:0] e_rd;
  logic [DW-1:0] m_q[$];

  function automatic logic [15:0] mk(bit fifo, int thr, int ivl, int cnt);
    return {4'(cnt), 8'(ivl), 3'(thr), fifo};
  endfunction

  function automatic int clampc(int c);
    if (c == 0) return 1;
    if (c > DEPTH) return DEPTH;
    return c;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_tick(bit vld, logic [DW-1:0] d, bit adv, bit clr, bit sync);
    bit fifo, full, expire, take, push, drop, pop, irqx;
    int thr, ivf, cc, occ_n;
    fifo   = m_cfg[0];
    thr    = int'(m_cfg[3:1]);
    ivf    = int'(m_cfg[11:4]);
    cc     = clampc(int'(m_cfg[15:12]));
    full   = (m_occ == DEPTH);
    expire = !fifo && vld && (m_ivl == ivf);
    take   = fifo ? vld : (expire || (vld && m_burst != 0));
    push   = take && !full;
    drop   = take && full;
    pop    = adv && (m_occ != 0);
    if (fifo) begin
      m_ivl = 0; m_burst = 0;
    end else if (vld) begin
      if (expire) begin
        m_ivl = 0; m_burst = full ? 0 : cc - 1;
      end else begin
        m_ivl = (m_ivl + 1) % 256;
        if (m_burst != 0) m_burst = full ? 0 : m_burst - 1;
      end
    end
    irqx = fifo && push && !pop && !clr && (m_occ + 1 == thr);
    e_rd_vld = 1'b0;
    if (clr) begin
      m_occ = 0;
      m_q.delete();
    end else begin
      if (pop) begin
        e_rd = m_q.pop_front();
        e_rd_vld = 1'b1;
      end
      if (push) m_q.push_back(d);
      m_occ = m_occ + int'(push) - int'(pop);
    end
    occ_n = m_occ;
    if (clr)              m_ready = 1'b0;
    else if (irqx)        m_ready = 1'b1;
    else if (occ_n < thr) m_ready = 1'b0;
    if (clr)       m_ovf = 1'b0;
    else if (drop) m_ovf = 1'b1;
    e_irq  = irqx;
    e_sync = sync;
  endtask

  task automatic compare(string tag);
    chk(tag, "level", 32'(level), 32'(m_occ));
    chk("R4", "irq", 32'(irq), 32'(e_irq));
    chk("R5", "ready", 32'(ready), 32'(m_ready));
    chk("R3", "ovf", 32'(ovf), 32'(m_ovf));
    chk("R10", "syncout", 32'(syncout), 32'(e_sync));
    if (e_rd_vld) chk("R2", "rd_data", 32'(rd_data), 32'(e_rd));
    if (irq) irq_seen++;
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic step(string tag, bit vld, logic [DW-1:0] d, bit adv, bit clr, bit sync);
    smp_vld = vld; smp_data = d; cmd_adv = adv; cmd_clr = clr; cmd_sync = sync;
    model_tick(vld, d, adv, clr, sync);
    @(posedge clk);
    @(negedge clk);
    smp_vld = 1'b0; cmd_adv = 1'b0; cmd_clr = 1'b0; cmd_sync = 1'b0;
    compare(tag);
  endtask

  task automatic wcfg(logic [15:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    model_tick(1'b0, '0, 1'b0, 1'b0, 1'b0);
    if (w[0] != m_cfg[0] || m_cfg[0]) begin m_ivl = 0; m_burst = 0; end
    m_cfg = w;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    compare("R11");
  endtask

  // Toggle the mode so the snapshot counter restarts, then apply w
  task automatic snap_restart(logic [15:0] w);
    wcfg(w | 16'h0001);
    wcfg(w);
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] hold;
    int ir0;
    void'($urandom(32'h5A17_C0DE));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; cmd_clr = 1'b0; cmd_adv = 1'b0;
    cmd_sync = 1'b0; smp_vld = 1'b0; smp_data = '0;
    m_cfg = '0; m_occ = 0; m_ivl = 0; m_burst = 0; m_ready = 0; m_ovf = 0;
    e_irq = 0; e_sync = 0; e_rd_vld = 0; e_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "level", 32'(level), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "ready", 32'(ready), 0);
    chk("R1", "ovf", 32'(ovf), 0);
    chk("R1", "syncout", 32'(syncout), 0);

    // R6: interval field 3, count 2 -> captures at samples 3,4,7,8,11
    snap_restart(mk(0, 0, 3, 2));
    for (int i = 0; i < 12; i++) step("R6", 1, DW'(16'h100 + i), 0, 0, 0);
    chk("R6", "snapshot level", 32'(level), 5);
    for (int i = 0; i < 5; i++) step("R6", 0, '0, 1, 0, 0);

    // R7: count 12 clamps to 8, interval field 9
    step("R8", 0, '0, 0, 1, 0);
    snap_restart(mk(0, 0, 9, 12));
    for (int i = 0; i < 18; i++) step("R7", 1, DW'(16'h200 + i), 0, 0, 0);
    chk("R7", "clamped burst level", 32'(level), 8);
    chk("R7", "no overflow", 32'(ovf), 0);
    step("R7", 0, '0, 1, 0, 0);
    chk("R7", "first burst sample", 32'(rd_data), 32'h209);
    // R7: count 0 acts as 1
    step("R8", 0, '0, 0, 1, 0);
    snap_restart(mk(0, 0, 2, 0));
    for (int i = 0; i < 9; i++) step("R7", 1, DW'(16'h300 + i), 0, 0, 0);
    chk("R7", "count zero level", 32'(level), 3);
    // R7: burst stops on full
    snap_restart(mk(0, 0, 0, 8));
    for (int i = 0; i < 8; i++) step("R7", 1, DW'(16'h380 + i), 0, 0, 0);
    chk("R7", "burst full level", 32'(level), 8);
    chk("R3", "burst full ovf", 32'(ovf), 1);

    // R11: mode change restarts counter, keeps data
    step("R8", 0, '0, 0, 1, 0);
    snap_restart(mk(0, 0, 7, 1));
    for (int i = 0; i < 5; i++) step("R11", 1, DW'(16'h400 + i), 0, 0, 0);
    wcfg(mk(1, 0, 7, 1));
    for (int i = 0; i < 2; i++) step("R11", 1, DW'(16'h410 + i), 0, 0, 0);
    wcfg(mk(0, 0, 7, 1));
    chk("R11", "data kept", 32'(level), 2);
    for (int i = 0; i < 7; i++) step("R11", 1, DW'(16'h420 + i), 0, 0, 0);
    chk("R11", "no early capture", 32'(level), 2);
    step("R11", 1, 16'h0427, 0, 0, 0);
    chk("R11", "capture after restart", 32'(level), 3);

    // R8 and R9: clear, advance on empty, then first sample back
    step("R8", 0, '0, 0, 1, 0);
    wcfg(mk(1, 0, 0, 0));
    hold = rd_data;
    step("R9", 0, '0, 1, 0, 0);
    chk("R9", "level on empty advance", 32'(level), 0);
    chk("R9", "rd_data unchanged", 32'(rd_data), 32'(hold));
    step("R8", 1, 16'hABCD, 0, 0, 0);
    step("R8", 0, '0, 1, 0, 0);
    chk("R8", "first after clear", 32'(rd_data), 32'hABCD);

    // R2..R5: FIFO threshold 5, overfill, drain
    step("R8", 0, '0, 0, 1, 0);
    wcfg(mk(1, 5, 0, 0));
    ir0 = irq_seen;
    for (int i = 0; i < 10; i++) step("R2", 1, DW'(16'h500 + i), 0, 0, 0);
    chk("R4", "single irq", 32'(irq_seen - ir0), 1);
    chk("R3", "full level", 32'(level), 8);
    chk("R3", "ovf set", 32'(ovf), 1);
    chk("R5", "ready set", 32'(ready), 1);
    for (int i = 0; i < 8; i++) step("R2", 0, '0, 1, 0, 0);
    chk("R5", "ready cleared", 32'(ready), 0);
    chk("R3", "ovf sticky", 32'(ovf), 1);
    // R4: threshold 0 never fires
    step("R8", 0, '0, 0, 1, 0);
    wcfg(mk(1, 0, 0, 0));
    ir0 = irq_seen;
    for (int i = 0; i < 8; i++) step("R4", 1, DW'(i), 0, 0, 0);
    chk("R4", "threshold zero silent", 32'(irq_seen - ir0), 0);

    // R10: back-to-back sync strobes
    step("R10", 0, '0, 0, 0, 1);
    step("R10", 0, '0, 0, 0, 1);
    step("R10", 0, '0, 0, 0, 0);

    // R12: random mix against the model
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0)
        wcfg(mk(($urandom % 3) != 0, $urandom % 8, $urandom % 12, $urandom % 16));
      step("R12", ($urandom % 3) != 0, DW'($urandom), ($urandom % 3) == 0,
           ($urandom % 97) == 0, ($urandom % 7) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule